// File: doc/BRIEF.md
# Bidirectional Saturating Arithmetic Shifter

This block shifts a signed fixed-point operand by a signed count. The operand is either the 16-bit short form, taken from the low half of the operand bus, or the full 32-bit long form. A 3-bit operation code selects the width and one of three kinds of shift: saturating left, arithmetic right, or arithmetic right with rounding.

A negative count turns the shift the other way. Left shifts clamp to the extreme value of the operand's sign when the exact result does not fit, and raise an overflow flag when they do. The rounding variants add back the last bit that was shifted out. Short results are sign-extended onto the 32-bit result bus.

A parameter places a register on the result and the flag, or leaves the path purely combinational. With the register, a two-state output stage tracks whether the held word is fresh. The state EMPTY moves to LOADED when `in_valid` is high, and LOADED returns to EMPTY when `in_valid` is low. Reset enters EMPTY.

Top module: `bidir_sat_shifter`

## Requirements
- R1: The operation code selects the operation: 0 short left, 1 short right, 2 short right with rounding, 3 long left, 4 long right, 5 long right with rounding. Short operations use `operand[15:0]` as a signed value, ignore `operand[31:16]`, and return the 16-bit result sign-extended to 32 bits.
- R2: A negative count makes any of the six operations shift in the opposite direction by the magnitude of the count. In that case a rounding operation applies no rounding.
- R3: A short left shift whose exact result is outside the signed 16-bit range returns 0x7FFF for a positive operand and 0xFFFF8000 for a negative one. This includes every count above 15 with a nonzero operand. A zero operand always returns 0.
- R4: A short right shift by 15 or more returns -1 for a negative operand and 0 otherwise. Smaller counts shift arithmetically and keep the sign.
- R5: A long left shift whose exact result is outside the signed 32-bit range returns 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one. A result that just fits, such as -1 shifted by 31, is returned exactly.
- R6: A long right shift by 31 or more returns -1 for a negative operand and 0 otherwise. Smaller counts shift arithmetically.
- R7: For a rounding operation with a positive count inside its range, the result is the arithmetic right shift plus bit (count-1) of the original operand. A count of 0 returns the operand unchanged.
- R8: A short rounding shift with a count above 15, and a long rounding shift with a count above 31, return 0.
- R9: `ovf` is high exactly when a left-direction shift was clamped to a saturation value. It is low for every right-direction shift.
- R10: Operation codes 6 and 7 return a result of 0 with `ovf` low.
- R11: With `PIPE_OUT`=1, `out_valid`, `result` and `ovf` reflect the inputs sampled at the previous rising clock edge, and the result holds while `in_valid` is low. With `PIPE_OUT`=0 they follow the current inputs in the same cycle.
- R12: After reset with `PIPE_OUT`=1, `out_valid`, `result` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current inputs as a request |
| op | input | 3 | Operation code (see R1) |
| operand | input | 32 | Operand; the low 16 bits are used for short operations |
| count | input | 16 | Signed shift count; a negative value reverses the direction |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Shifted result, with short results sign-extended |
| ovf | output | 1 | A left shift was clamped |

## Verification
The bench builds two copies of the block side by side: one with `PIPE_OUT`=1 and one with `PIPE_OUT`=0. Both are driven from the same inputs. Comparing them in the same cycle exposes the one-cycle latency, the hold behaviour of the register and the reset state. Both copies are also checked against a behavioural model that saturates left shifts step by step.

The directed vectors sit on the edges that matter: the 15/16 and 31/32 count boundaries, the operands 0x4000, 0x8000, 0xC0000000 and -1, the most negative count, and the reserved operation codes. These are followed by random operations with counts drawn both near the width limits and across the full signed range.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        OP_SL16  = 3'd0,
        OP_SR16  = 3'd1,
        OP_SRR16 = 3'd2,
        OP_SL32  = 3'd3,
        OP_SR32  = 3'd4,
        OP_SRR32 = 3'd5
    } shf_op_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } stage_state_e;

endpackage

// File: rtl/shf_sat_left.sv
module shf_sat_left #(
    parameter int W     = 16,
    parameter int AMT_W = 17
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout,
    output logic             sat
);
    localparam int LW = $clog2(W);

    logic [2*W-1:0] ext;
    logic           big;
    logic           fits;

    always_comb begin
        big  = (amt >= AMT_W'(W));
        ext  = {{W{din[W-1]}}, din} << amt[LW-1:0];
        if (big) begin
            fits = (din == '0);
        end else begin
            fits = (ext[2*W-1:W-1] == {(W+1){ext[W-1]}});
        end
        sat = !fits;
        if (!fits) begin
            dout = din[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else if (big) begin
            dout = '0;
        end else begin
            dout = ext[W-1:0];
        end
    end

endmodule

// File: rtl/shf_asr_round.sv
module shf_asr_round #(
    parameter int W     = 16,
    parameter int AMT_W = 17
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  logic             round_en,
    output logic [W-1:0]     dout
);
    localparam int LW = $clog2(W);

    logic signed [W-1:0] shifted;
    logic [LW-1:0]       idx;
    logic                rbit;

    always_comb begin
        idx = amt[LW-1:0] - LW'(1);
        if (amt >= AMT_W'(W-1)) begin
            shifted = {W{din[W-1]}};
        end else begin
            shifted = $signed(din) >>> amt[LW-1:0];
        end
        rbit = round_en && (amt != '0) && (amt < AMT_W'(W)) && din[idx];
        if (round_en && (amt >= AMT_W'(W))) begin
            dout = '0;
        end else begin
            dout = W'(shifted) + W'(rbit);
        end
    end

endmodule

// File: rtl/shf_lane.sv
module shf_lane #(
    parameter int W     = 16,
    parameter int AMT_W = 17
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    input  logic             go_left,
    input  logic             round_en,
    output logic [W-1:0]     dout,
    output logic             sat
);
    logic [W-1:0] left_res;
    logic [W-1:0] right_res;
    logic         left_sat;

    shf_sat_left #(.W(W), .AMT_W(AMT_W)) u_left (
        .din  (din),
        .amt  (amt),
        .dout (left_res),
        .sat  (left_sat)
    );

    shf_asr_round #(.W(W), .AMT_W(AMT_W)) u_right (
        .din      (din),
        .amt      (amt),
        .round_en (round_en),
        .dout     (right_res)
    );

    always_comb begin
        dout = go_left ? left_res : right_res;
        sat  = go_left & left_sat;
    end

endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage
    import shf_pkg::*;
#(
    parameter int DW   = 32,
    parameter int PIPE = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] d_res,
    input  logic          d_ovf,
    output logic          out_valid,
    output logic [DW-1:0] q_res,
    output logic          q_ovf
);
    generate
        if (PIPE != 0) begin : g_reg
            stage_state_e  state_q;
            stage_state_e  state_d;
            logic [DW-1:0] res_q;
            logic          ovf_q;

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    ST_EMPTY:  if (in_valid)  state_d = ST_LOADED;
                    ST_LOADED: if (!in_valid) state_d = ST_EMPTY;
                    default:                  state_d = ST_EMPTY;
                endcase
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= ST_EMPTY;
                else        state_q <= state_d;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_q <= '0;
                    ovf_q <= 1'b0;
                end else if (in_valid) begin
                    res_q <= d_res;
                    ovf_q <= d_ovf;
                end
            end

            assign out_valid = (state_q == ST_LOADED);
            assign q_res     = res_q;
            assign q_ovf     = ovf_q;

            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid) else $error("valid not raised"); // R11
            AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid) else $error("valid not dropped"); // R11
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> ($stable(q_res) && $stable(q_ovf))) else $error("held result changed"); // R11
        end else begin : g_comb
            assign out_valid = in_valid;
            assign q_res     = d_res;
            assign q_ovf     = d_ovf;
        end
    endgenerate

endmodule

// File: rtl/bidir_sat_shifter.sv
module bidir_sat_shifter
    import shf_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int CNT_W    = 16,
    parameter int PIPE_OUT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [WIDE_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    output logic              out_valid,
    output logic [WIDE_W-1:0] result,
    output logic              ovf
);
    localparam int MAG_W = CNT_W + 1;

    logic                is_short;
    logic                is_long;
    logic                base_left;
    logic                rnd_op;
    logic                neg_cnt;
    logic [MAG_W-1:0]    mag;
    logic                go_left;
    logic                round_en;
    logic [NARROW_W-1:0] res_n;
    logic                sat_n;
    logic [WIDE_W-1:0]   res_w;
    logic                sat_w;
    logic [WIDE_W-1:0]   res_c;
    logic                ovf_c;
    logic                src_sign;

    always_comb begin
        is_short  = (op == OP_SL16) || (op == OP_SR16) || (op == OP_SRR16);
        is_long   = (op == OP_SL32) || (op == OP_SR32) || (op == OP_SRR32);
        base_left = (op == OP_SL16) || (op == OP_SL32);
        rnd_op    = (op == OP_SRR16) || (op == OP_SRR32);
        neg_cnt   = count[CNT_W-1];
        mag       = neg_cnt ? (MAG_W'(0) - {1'b1, count}) : {1'b0, count};
        go_left   = base_left ^ neg_cnt;
        round_en  = rnd_op & ~neg_cnt;
    end

    shf_lane #(.W(NARROW_W), .AMT_W(MAG_W)) u_lane_short (
        .din      (operand[NARROW_W-1:0]),
        .amt      (mag),
        .go_left  (go_left),
        .round_en (round_en),
        .dout     (res_n),
        .sat      (sat_n)
    );

    shf_lane #(.W(WIDE_W), .AMT_W(MAG_W)) u_lane_long (
        .din      (operand),
        .amt      (mag),
        .go_left  (go_left),
        .round_en (round_en),
        .dout     (res_w),
        .sat      (sat_w)
    );

    always_comb begin
        if (is_short) begin
            res_c    = {{(WIDE_W-NARROW_W){res_n[NARROW_W-1]}}, res_n};
            ovf_c    = sat_n;
            src_sign = operand[NARROW_W-1];
        end else if (is_long) begin
            res_c    = res_w;
            ovf_c    = sat_w;
            src_sign = operand[WIDE_W-1];
        end else begin
            res_c    = '0;
            ovf_c    = 1'b0;
            src_sign = 1'b0;
        end
    end

    always_comb begin
        AST_SEXT16: assert (!is_short ||
            (res_c[WIDE_W-1:NARROW_W-1] == {(WIDE_W-NARROW_W+1){res_c[NARROW_W-1]}}))
            else $error("short result not sign-extended"); // R1
        AST_RESERVED_ZERO: assert (is_short || is_long || (res_c == '0 && !ovf_c))
            else $error("reserved op produced output"); // R10
        AST_SAT_SIGN: assert (!ovf_c || (res_c[WIDE_W-1] == src_sign))
            else $error("clamp sign wrong"); // R3
        AST_OVF_LEFT_ONLY: assert (!ovf_c || go_left)
            else $error("overflow on right shift"); // R9
    end

    shf_out_stage #(.DW(WIDE_W), .PIPE(PIPE_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_res     (res_c),
        .d_ovf     (ovf_c),
        .out_valid (out_valid),
        .q_res     (result),
        .q_ovf     (ovf)
    );

endmodule

// File: tb/bidir_sat_shifter_tb.sv
module bidir_sat_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] operand = 32'd0;
    logic [15:0] count = 16'd0;

    logic        pv, cv;
    logic [31:0] pres, cres;
    logic        povf, covf;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] q_res[$];
    logic        q_ovf[$];
    logic        q_vld[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    bidir_sat_shifter #(.PIPE_OUT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .operand(operand), .count(count),
        .out_valid(pv), .result(pres), .ovf(povf)
    );

    bidir_sat_shifter #(.PIPE_OUT(0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .operand(operand), .count(count),
        .out_valid(cv), .result(cres), .ovf(covf)
    );

    function automatic void ref_model(input logic [2:0] f_op, input logic [31:0] f_opnd,
                                      input logic [15:0] f_cnt,
                                      output logic [31:0] f_res, output logic f_ovf);
        longint v, maxv, minv;
        int     w, n;
        bit     left, rnd, rb;
        f_res = 32'd0;
        f_ovf = 1'b0;
        if (f_op > 3'd5) return;
        w    = (f_op < 3'd3) ? 16 : 32;
        v    = (w == 16) ? longint'($signed(f_opnd[15:0])) : longint'($signed(f_opnd));
        maxv = (64'sd1 <<< (w - 1)) - 1;
        minv = -maxv - 1;
        left = (f_op == 3'd0) || (f_op == 3'd3);
        rnd  = (f_op == 3'd2) || (f_op == 3'd5);
        n    = int'($signed(f_cnt));
        if (n < 0) begin
            left = !left;
            n    = -n;
            rnd  = 0;
        end
        if (left) begin
            for (int k = 0; k < n; k++) begin
                if (v == 0) break;
                v = v * 2;
                if (v > maxv) begin v = maxv; f_ovf = 1'b1; break; end
                if (v < minv) begin v = minv; f_ovf = 1'b1; break; end
            end
        end else if (rnd && n > w - 1) begin
            v = 0;
        end else begin
            rb = rnd && (n > 0) && (((v >>> (n - 1)) & 1) != 0);
            v  = v >>> ((n > w) ? w : n);
            if (rb) v = v + 1;
        end
        f_res = v[31:0];
    endfunction

    function automatic string tag_of(input logic [2:0] t_op, input logic [15:0] t_cnt);
        if (t_cnt[15] && t_op <= 3'd5) return "R2";
        case (t_op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R7";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (op=%0d opnd=%h cnt=%0d)",
                     tag, act, exp, op, operand, $signed(count));
        end
    endtask

    task automatic step(input logic [2:0] s_op, input logic [31:0] s_opnd,
                        input logic [15:0] s_cnt, input logic s_vld, input string s_tag);
        logic [31:0] e_res, p_res;
        logic        e_ovf, p_ovf, p_vld;
        string       p_tag;
        @(negedge clk);
        p_res = q_res.pop_front();
        p_ovf = q_ovf.pop_front();
        p_vld = q_vld.pop_front();
        p_tag = q_tag.pop_front();
        chk("R11", 32'(pv), 32'(p_vld));
        if (p_vld) begin
            chk(p_tag, pres, p_res);
            chk("R9", 32'(povf), 32'(p_ovf));
        end
        op = s_op; operand = s_opnd; count = s_cnt; in_valid = s_vld;
        #1;
        ref_model(s_op, s_opnd, s_cnt, e_res, e_ovf);
        chk("R11", 32'(cv), 32'(s_vld));
        if (s_vld) begin
            chk(s_tag, cres, e_res);
            chk("R9", 32'(covf), 32'(e_ovf));
        end
        chk("R11", 32'(pv), 32'(p_vld));
        if (p_vld) chk("R11", pres, p_res);
        if (!s_vld && p_vld) begin
            e_res = p_res;
            e_ovf = p_ovf;
        end
        q_res.push_back(s_vld ? e_res : (p_vld ? p_res : 32'd0));
        q_ovf.push_back(s_vld ? e_ovf : p_ovf);
        q_vld.push_back(s_vld);
        q_tag.push_back(s_vld ? s_tag : "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state of the registered copy
        chk("R12", 32'(pv), 32'd0);
        chk("R12", pres, 32'd0);
        chk("R12", 32'(povf), 32'd0);
        rst_n = 1'b1;
        q_res.push_back(32'd0); q_ovf.push_back(1'b0); q_vld.push_back(1'b0); q_tag.push_back("R12");

        // R1: short forms ignore the upper half, results sign-extended
        step(3'd1, 32'h0000_8000, 16'd1, 1, "R1");
        step(3'd0, 32'hABCD_0001, 16'd3, 1, "R1");
        step(3'd1, 32'h7FFF_FFFF, 16'd1, 1, "R1");
        // R3: short left clamp
        step(3'd0, 32'h0000_4000, 16'd1, 1, "R3");
        step(3'd0, 32'h0000_FFFF, 16'd15, 1, "R3");
        step(3'd0, 32'h0000_FFFF, 16'd16, 1, "R3");
        step(3'd0, 32'h0000_0001, 16'd20, 1, "R3");
        step(3'd0, 32'h0000_0000, 16'd100, 1, "R3");
        // R4: short right
        step(3'd1, 32'h0000_8000, 16'd15, 1, "R4");
        step(3'd1, 32'h0000_8000, 16'd40, 1, "R4");
        step(3'd1, 32'h0000_7FFF, 16'd15, 1, "R4");
        step(3'd1, 32'h0000_FFFB, 16'd1, 1, "R4");
        // R2: negative counts
        step(3'd0, 32'h0000_FFF8, -16'sd2, 1, "R2");
        step(3'd1, 32'h0000_1000, -16'sd3, 1, "R2");
        step(3'd3, 32'hFFFF_FFFF, 16'h8000, 1, "R2");
        step(3'd2, 32'h0000_0003, -16'sd1, 1, "R2");
        step(3'd5, 32'h4000_0000, -16'sd1, 1, "R2");
        // R5: long left clamp
        step(3'd3, 32'h4000_0000, 16'd1, 1, "R5");
        step(3'd3, 32'hC000_0000, 16'd1, 1, "R5");
        step(3'd3, 32'hFFFF_FFFF, 16'd31, 1, "R5");
        step(3'd3, 32'hFFFF_FFFF, 16'd32, 1, "R5");
        step(3'd3, 32'h0000_0003, 16'd29, 1, "R5");
        step(3'd3, 32'h0000_0003, 16'd30, 1, "R5");
        // R6: long right
        step(3'd4, 32'h8000_0000, 16'd31, 1, "R6");
        step(3'd4, 32'h7FFF_FFFF, 16'd31, 1, "R6");
        step(3'd4, 32'h8000_0000, 16'd4, 1, "R6");
        // R7: rounding
        step(3'd2, 32'h0000_0005, 16'd1, 1, "R7");
        step(3'd2, 32'h0000_FFFB, 16'd1, 1, "R7");
        step(3'd2, 32'h0000_4000, 16'd15, 1, "R7");
        step(3'd5, 32'h8000_0000, 16'd31, 1, "R7");
        step(3'd5, 32'h4000_0000, 16'd31, 1, "R7");
        step(3'd5, 32'h1234_5678, 16'd0, 1, "R7");
        // R8: rounding counts past the range
        step(3'd2, 32'h0000_4000, 16'd16, 1, "R8");
        step(3'd2, 32'h0000_FFFF, 16'd16, 1, "R8");
        step(3'd5, 32'hFFFF_FFFF, 16'd32, 1, "R8");
        step(3'd5, 32'hFFFF_FFFF, 16'd31, 1, "R8");
        // R10: reserved codes
        step(3'd6, 32'h4000_0000, 16'd1, 1, "R10");
        step(3'd7, 32'hFFFF_FFFF, 16'd3, 1, "R10");
        // R11: idle cycles hold the registered result
        step(3'd3, 32'h0000_0001, 16'd4, 0, "R11");
        step(3'd1, 32'h0000_0100, 16'd2, 0, "R11");
        step(3'd0, 32'h0000_0100, 16'd2, 1, "R11");

        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  r_op;
            logic [15:0] r_cnt;
            logic [31:0] r_opnd;
            r_op   = 3'($urandom_range(0, 7));
            r_opnd = $urandom();
            case ($urandom_range(0, 3))
                0: r_opnd = r_opnd >> $urandom_range(0, 31);
                1: r_opnd = $signed(r_opnd) >>> $urandom_range(0, 31);
                default: ;
            endcase
            case ($urandom_range(0, 2))
                0: r_cnt = 16'($urandom_range(0, 34));
                1: r_cnt = 16'(-$signed($urandom_range(0, 34)));
                default: r_cnt = 16'($urandom());
            endcase
            step(r_op, r_opnd, r_cnt, ($urandom_range(0, 5) != 0), tag_of(r_op, r_cnt));
        end
        step(3'd0, 32'd0, 16'd0, 0, "R11");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule